// File: doc/BRIEF.md
# Priority Ternary Lookup Table

This block is a small lookup table of ENTRIES slots. Each slot holds a ternary key, a result value and a valid flag. In the ternary key, each bit is stored as 0, 1 or "either". Any value can be held in the result, for example the egress port of a route. The write port loads a whole slot in one cycle.

The search port takes a plain binary key and compares it against every slot at the same time. The outputs report whether any slot accepted the key, the position of the winning slot and the result stored there. When more than one slot accepts the key, the slot at the smallest position wins.

Results are registered and appear one clock after the search strobe. A write issued in the same cycle as a search is seen only by later searches.

Top module: `tcam_lookup`

## Requirements
- R1: Each key bit is stored as a two-bit code: 2'b01 means the slot bit must be 0, and 2'b10 means it must be 1. Bit b of the key sits in wrKey[2b+1:2b]. A valid slot matches only when every such bit equals the search bit, and one differing bit makes it a miss.
- R2: The code 2'b00 marks a bit as "either", and that bit matches a search bit of 0 or 1.
- R3: A slot in which any bit carries the code 2'b11 never matches, whatever the search key.
- R4: A slot written with the valid flag at 0 never matches.
- R5: When several valid slots match, hitIdx and hitResult report the slot with the lowest position.
- R6: When no valid slot matches, hit is 0 and hitIdx and hitResult are both 0.
- R7: hit, hitIdx and hitResult change one clock after srchEn is sampled high, and rspValid is high in exactly that cycle. In cycles without a search the outputs keep their values.
- R8: A write sampled in the same cycle as a search does not affect that search's result. It does affect the next search.
- R9: A write whose wrIdx is ENTRIES or above changes no slot.
- R10: After reset every slot is invalid, and hit, hitIdx, hitResult and rspValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load slot wrIdx this cycle |
| wrIdx | input | IDX_W | Slot position to load |
| wrKey | input | 2*KEY_W | Ternary key, two code bits per key bit |
| wrResult | input | RES_W | Result value stored with the key |
| wrValid | input | 1 | Valid flag stored with the key |
| srchEn | input | 1 | Search strobe |
| srchKey | input | KEY_W | Binary key to look up |
| rspValid | output | 1 | High in the cycle after a search |
| hit | output | 1 | At least one valid slot matched |
| hitIdx | output | IDX_W | Position of the winning slot |
| hitResult | output | RES_W | Result stored in the winning slot |

## Verification
The bench uses ENTRIES=6, KEY_W=8 and RES_W=4. With six slots, a three-bit index can still address positions 6 and 7, so writes to those positions can be driven and shown to have no effect. An 8-bit key, paired with random care masks built from ANDed random words, makes overlapping slots common, so both the lowest-position rule and the miss path come up often. Illegal 2'b11 codes are injected at random so that poisoned slots mix with legal ones.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [1:0] {
    TERN_ANY  = 2'b00,
    TERN_ZERO = 2'b01,
    TERN_ONE  = 2'b10,
    TERN_BAD  = 2'b11
  } ternCode_e;

  typedef struct packed {
    logic loadEntry;
    logic captureResult;
  } tcamStrobe_t;

  function automatic logic ternBitHit(input logic [1:0] code, input logic keyBit);
    logic ok;
    case (ternCode_e'(code))
      TERN_ANY:  ok = 1'b1;
      TERN_ZERO: ok = ~keyBit;
      TERN_ONE:  ok = keyBit;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int IDX_W   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic        srchEn,
  output tcamStrobe_t strobe,
  output logic        rspValid
);

  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(ENTRIES);

  logic idxInRange;

  always_comb begin
    idxInRange           = ({1'b0, wrIdx} < LAST_IDX);
    strobe.loadEntry     = wrEn && idxInRange;
    strobe.captureResult = srchEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= srchEn;
  end

  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    srchEn |=> rspValid);
  assert_rsp_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> !rspValid);

endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int KEY_W   = 8,
  parameter int RES_W   = 4,
  parameter int IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tcamStrobe_t          strobe,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [2*KEY_W-1:0]   wrKey,
  input  logic [RES_W-1:0]     wrResult,
  input  logic                 wrValid,
  input  logic [KEY_W-1:0]     srchKey,
  output logic                 hitQ,
  output logic [IDX_W-1:0]     idxQ,
  output logic [RES_W-1:0]     resQ
);

  localparam int CODE_W = 2 * KEY_W;

  logic [CODE_W-1:0]  keyMem [ENTRIES];
  logic [RES_W-1:0]   resMem [ENTRIES];
  logic [ENTRIES-1:0] validMem;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] grantVec;
  logic               anyHit;
  logic [IDX_W-1:0]   winIdx;
  logic [RES_W-1:0]   winResult;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [KEY_W-1:0] bitHit;
    logic [KEY_W-1:0] badBit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validMem[e] <= 1'b0;
        keyMem[e]   <= '0;
        resMem[e]   <= '0;
      end else if (strobe.loadEntry && (wrIdx == IDX_W'(e))) begin
        validMem[e] <= wrValid;
        keyMem[e]   <= wrKey;
        resMem[e]   <= wrResult;
      end
    end

    for (genvar b = 0; b < KEY_W; b++) begin : g_bit
      always_comb begin
        bitHit[b] = ternBitHit(keyMem[e][2*b+1:2*b], srchKey[b]);
        badBit[b] = (keyMem[e][2*b+1:2*b] == TERN_BAD);
      end
    end

    always_comb matchVec[e] = validMem[e] && (&bitHit);

    assert_bad_code_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
      (|badBit) |-> !matchVec[e]);
    assert_invalid_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
      !validMem[e] |-> !matchVec[e]);
  end

  always_comb begin
    grantVec = '0;
    winIdx   = '0;
    anyHit   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i] && !anyHit) begin
        anyHit      = 1'b1;
        grantVec[i] = 1'b1;
        winIdx      = IDX_W'(i);
      end
    end
  end

  always_comb begin
    winResult = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grantVec[i]) winResult = winResult | resMem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ <= 1'b0;
      idxQ <= '0;
      resQ <= '0;
    end else if (strobe.captureResult) begin
      hitQ <= anyHit;
      idxQ <= winIdx;
      resQ <= winResult;
    end
  end

  assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
  assert_winner_in_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> ({1'b0, idxQ} < (IDX_W+1)'(ENTRIES)));
  assert_miss_zeroes_R6: assert property (@(posedge clk) disable iff (!rstN)
    !hitQ |-> (idxQ == '0 && resQ == '0));
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureResult |=> ($stable(hitQ) && $stable(idxQ) && $stable(resQ)));

endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int KEY_W   = 8,
  parameter int RES_W   = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [2*KEY_W-1:0] wrKey,
  input  logic [RES_W-1:0]   wrResult,
  input  logic               wrValid,
  input  logic               srchEn,
  input  logic [KEY_W-1:0]   srchKey,
  output logic               rspValid,
  output logic               hit,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [RES_W-1:0]   hitResult
);

  tcamStrobe_t strobe;

  tcam_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx),
    .srchEn(srchEn), .strobe(strobe), .rspValid(rspValid)
  );

  tcam_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .wrKey(wrKey),
    .wrResult(wrResult), .wrValid(wrValid), .srchKey(srchKey),
    .hitQ(hit), .idxQ(hitIdx), .resQ(hitResult)
  );

endmodule

// File: tb/sim_tcam_lookup.sv
module sim_tcam_lookup;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 6;
  localparam int KEY_W = 8;
  localparam int RES_W = 4;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [2*KEY_W-1:0] wrKey = '0;
  logic [RES_W-1:0] wrResult = '0;
  logic wrValid = 1'b0;
  logic srchEn = 1'b0;
  logic [KEY_W-1:0] srchKey = '0;
  logic rspValid, hit;
  logic [IDX_W-1:0] hitIdx;
  logic [RES_W-1:0] hitResult;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [2*KEY_W-1:0] mKey [ENTRIES];
  logic [RES_W-1:0]   mRes [ENTRIES];
  logic               mVal [ENTRIES];

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .RES_W(RES_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrKey(wrKey),
    .wrResult(wrResult), .wrValid(wrValid), .srchEn(srchEn), .srchKey(srchKey),
    .rspValid(rspValid), .hit(hit), .hitIdx(hitIdx), .hitResult(hitResult)
  );

  function automatic logic [2*KEY_W-1:0] enc(input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] care);
    logic [2*KEY_W-1:0] k = '0;
    for (int b = 0; b < KEY_W; b++)
      k[2*b +: 2] = care[b] ? (v[b] ? 2'b10 : 2'b01) : 2'b00;
    return k;
  endfunction

  function automatic bit slotMatches(input int e, input logic [KEY_W-1:0] s);
    if (!mVal[e]) return 1'b0;
    for (int b = 0; b < KEY_W; b++) begin
      logic [1:0] c = mKey[e][2*b +: 2];
      if (c == 2'b11) return 1'b0;
      if (c == 2'b01 && s[b]) return 1'b0;
      if (c == 2'b10 && !s[b]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional search, checked one clock later
  task automatic op(input bit doWr, input int wIdx, input logic [2*KEY_W-1:0] wKey,
                    input int wRes, input bit wVal, input bit doSrch,
                    input logic [KEY_W-1:0] sKey, input string req);
    int expHit = 0, expIdx = 0, expRes = 0;
    int oldHit = hit, oldIdx = hitIdx, oldRes = hitResult;
    if (doSrch) begin
      for (int e = ENTRIES - 1; e >= 0; e--)
        if (slotMatches(e, sKey)) begin expHit = 1; expIdx = e; expRes = mRes[e]; end
    end
    wrEn = doWr; wrIdx = IDX_W'(wIdx); wrKey = wKey; wrResult = RES_W'(wRes);
    wrValid = wVal; srchEn = doSrch; srchKey = sKey;
    @(posedge clk);
    if (doWr && wIdx < ENTRIES) begin
      mKey[wIdx] = wKey; mRes[wIdx] = RES_W'(wRes); mVal[wIdx] = wVal;
    end
    @(negedge clk);
    wrEn = 1'b0; srchEn = 1'b0;
    if (doSrch) begin
      check({req, " R7 rspValid"}, rspValid, 1);
      check({req, " hit"}, hit, expHit);
      check({req, " hitIdx"}, hitIdx, expIdx);
      check({req, " hitResult"}, hitResult, expRes);
    end else begin
      check("R7 rspValid idle", rspValid, 0);
      check("R7 hold hit", hit, oldHit);
      check("R7 hold idx", hitIdx, oldIdx);
      check("R7 hold res", hitResult, oldRes);
    end
  endtask

  task automatic search(input logic [KEY_W-1:0] k, input string req);
    op(1'b0, 0, '0, 0, 1'b0, 1'b1, k, req);
  endtask

  task automatic wr(input int i, input logic [2*KEY_W-1:0] k, input int r, input bit v);
    op(1'b1, i, k, r, v, 1'b0, '0, "write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int e = 0; e < ENTRIES; e++) begin mKey[e] = '0; mRes[e] = '0; mVal[e] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check("R10 hit", hit, 0);
    check("R10 hitIdx", hitIdx, 0);
    check("R10 hitResult", hitResult, 0);
    check("R10 rspValid", rspValid, 0);
    search(8'h00, "R10 empty table miss");
    // R1 exact match and single-bit miss
    wr(2, enc(8'h5A, 8'hFF), 3, 1'b1);
    search(8'h5A, "R1 exact hit");
    search(8'h5B, "R1 one bit differs R6");
    // R2 partial don't-care, R5 priority
    wr(4, enc(8'h50, 8'hF0), 7, 1'b1);
    search(8'h5A, "R5 lower slot wins");
    search(8'h53, "R2 dont-care low nibble");
    search(8'h5F, "R2 dont-care ones");
    wr(1, enc(8'h00, 8'h00), 9, 1'b1);
    search(8'h5A, "R5 R2 all dont-care slot wins");
    // R4 invalid slot
    wr(1, enc(8'h00, 8'h00), 9, 1'b0);
    search(8'h5A, "R4 invalid slot skipped");
    // R3 illegal code
    wr(0, 16'h0003, 5, 1'b1);
    search(8'h00, "R3 code 11 miss");
    search(8'h01, "R3 code 11 miss one");
    // R8 same-cycle write and search
    op(1'b1, 0, enc(8'h00, 8'h00), 6, 1'b1, 1'b1, 8'h00, "R8 same cycle old view");
    search(8'h00, "R8 next search sees write");
    // R9 out-of-range writes
    wr(0, enc(8'h00, 8'h00), 0, 1'b0);
    wr(7, enc(8'h00, 8'h00), 11, 1'b1);
    wr(6, enc(8'h00, 8'h00), 12, 1'b1);
    search(8'h00, "R9 oob write ignored");
    search(8'h5A, "R9 slot 2 untouched");
    // R7 idle hold
    op(1'b0, 0, '0, 0, 1'b0, 1'b0, '0, "R7 idle");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 9);
      logic [KEY_W-1:0] v = KEY_W'($urandom);
      logic [KEY_W-1:0] care = KEY_W'($urandom & $urandom);
      logic [2*KEY_W-1:0] k = enc(v, care);
      if ($urandom_range(0, 7) == 0) k[2*$urandom_range(0, KEY_W-1) +: 2] = 2'b11;
      if (kind < 3)
        wr($urandom_range(0, 7), k, $urandom_range(0, 15), $urandom_range(0, 3) != 0);
      else if (kind < 8)
        search(KEY_W'($urandom), "R1 R5 random");
      else if (kind == 8)
        op(1'b1, $urandom_range(0, 7), k, $urandom_range(0, 15), 1'b1, 1'b1,
           KEY_W'($urandom), "R8 random same cycle");
      else
        op(1'b0, 0, '0, 0, 1'b0, 1'b0, '0, "R7 random idle");
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule